// File: doc/BRIEF.md
# Keyed XOR Data Vault

The block keeps one secret key word and one data word, both `W` bits wide. A four-state controller moves between them. Four command strobes share a single input bus. One strobe wipes everything. One captures the bus as the key. One stores the bus XOR the key as ciphertext. One turns the stored ciphertext back into plaintext by XOR with the key.

Plaintext is short-lived. If nothing replaces it, it is cleared in the cycle after it appears and the controller returns to the keyed-but-empty condition.

When several strobes are raised together, a fixed priority decides which one acts. Strobes that need a key or ciphertext are ignored until that precondition holds.

All outputs come from registers. A command sampled at a rising clock edge shows at the outputs just after that edge.

Top module: `xor_seal_fsm`

## Requirements
- R1: Reset (synchronous, active high) leaves `state`=0, `dout`=0, `full`=0 and `sealed`=0. The state codes are 0=empty, 1=keyed, 2=ciphertext held, 3=plaintext held.
- R2: `clr_cmd` has the highest priority and acts in every state. It zeroes the key and the data word and moves to state 0.
- R3: `key_cmd` is next in priority. It loads `din` as the key, zeroes the data word and moves to state 1, overriding `enc_cmd` and `dec_cmd`.
- R4: In states 1, 2 or 3, `enc_cmd` without a higher-priority strobe stores `din` XOR key as the data word and moves to state 2. It wins over `dec_cmd`.
- R5: In state 2, `dec_cmd` alone replaces the data word with data XOR key and moves to state 3. The result equals the word that was encrypted.
- R6: State 3 lasts exactly one cycle. Without `clr_cmd`, `key_cmd` or `enc_cmd`, the next edge zeroes the data word and moves to state 1.
- R7: In state 0, `enc_cmd` and `dec_cmd` are ignored: `state` and `dout` stay 0.
- R8: `dec_cmd` in state 1 or state 3 is ignored. In state 3 the scrub of R6 still happens.
- R9: With no strobe raised in state 1 or 2, state and data word hold.
- R10: `full` is 1 exactly in states 2 and 3. `sealed` is 1 exactly in state 2. `dout` is 0 whenever `full` is 0.
- R11: Outputs change only at the rising edge that samples a command, never before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_cmd | input | 1 | Wipe key and data |
| key_cmd | input | 1 | Load `din` as key |
| enc_cmd | input | 1 | Store `din` XOR key |
| dec_cmd | input | 1 | Decrypt stored word |
| din | input | W | Key or payload bus |
| dout | output | W | Data register contents |
| full | output | 1 | Data word holds valid data |
| sealed | output | 1 | Data word holds ciphertext |
| state | output | 2 | Controller state code |

## Verification
The automatic scrub of a plaintext word can fall in the same cycle as a new command. The bench provokes this by raising `enc_cmd` in the plaintext cycle, which must store new ciphertext instead of zeroing. It also raises `dec_cmd` there, which must be ignored while the scrub proceeds. Strobe overlaps are provoked as well: `enc_cmd` with `dec_cmd`, `key_cmd` with `enc_cmd`, and all four together. Each is judged by the resulting state code and data word one edge later.

// File: rtl/xor_seal_pkg.sv
package xor_seal_pkg;

  typedef enum logic [1:0] {
    ST_EMPTY  = 2'd0,
    ST_READY  = 2'd1,
    ST_CIPHER = 2'd2,
    ST_PLAIN  = 2'd3
  } seal_state_e;

  typedef enum logic [2:0] {
    ACT_HOLD  = 3'd0,
    ACT_WIPE  = 3'd1,
    ACT_KEY   = 3'd2,
    ACT_SEAL  = 3'd3,
    ACT_OPEN  = 3'd4,
    ACT_SCRUB = 3'd5
  } seal_act_e;

  typedef struct packed {
    logic wipe;
    logic key;
    logic seal;
    logic open;
  } seal_cmd_t;

  // Priority: wipe > key > seal > open; scrub of plaintext when nothing acts.
  function automatic seal_act_e pick_action(seal_cmd_t c, seal_state_e s);
    if (c.wipe)                      return ACT_WIPE;
    if (c.key)                       return ACT_KEY;
    if (c.seal && s != ST_EMPTY)     return ACT_SEAL;
    if (c.open && s == ST_CIPHER)    return ACT_OPEN;
    if (s == ST_PLAIN)               return ACT_SCRUB;
    return ACT_HOLD;
  endfunction

  function automatic seal_state_e next_state(seal_act_e a, seal_state_e s);
    case (a)
      ACT_WIPE:  return ST_EMPTY;
      ACT_KEY:   return ST_READY;
      ACT_SEAL:  return ST_CIPHER;
      ACT_OPEN:  return ST_PLAIN;
      ACT_SCRUB: return ST_READY;
      default:   return s;
    endcase
  endfunction

endpackage

// File: rtl/xor_seal_arbiter.sv
module xor_seal_arbiter
  import xor_seal_pkg::*;
(
  input  seal_cmd_t   cmd,
  input  seal_state_e cur,
  output seal_act_e   act,
  output seal_state_e nxt
);

  always_comb begin
    act = pick_action(cmd, cur);
    nxt = next_state(act, cur);
  end

endmodule

// File: rtl/xor_seal_regs.sv
module xor_seal_regs
  import xor_seal_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  seal_act_e    act,
  input  logic [W-1:0] din,
  output logic [W-1:0] data_q
);

  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] key_q;

  function automatic logic [W-1:0] mix(input logic [W-1:0] a, input logic [W-1:0] b);
    return a ^ b;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q  <= ZERO;
      data_q <= ZERO;
    end else begin
      case (act)
        ACT_WIPE: begin
          key_q  <= ZERO;
          data_q <= ZERO;
        end
        ACT_KEY: begin
          key_q  <= din;
          data_q <= ZERO;
        end
        ACT_SEAL:  data_q <= mix(din, key_q);
        ACT_OPEN:  data_q <= mix(data_q, key_q);
        ACT_SCRUB: data_q <= ZERO;
        default: ;
      endcase
    end
  end

  // R2
  wipe_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_WIPE) |=> (key_q == ZERO && data_q == ZERO));

  // R5
  roundtrip_chk: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_OPEN && $past(act) == ACT_SEAL) |=> (data_q == $past(din, 2)));

endmodule

// File: rtl/xor_seal_fsm.sv
module xor_seal_fsm
  import xor_seal_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_cmd,
  input  logic         key_cmd,
  input  logic         enc_cmd,
  input  logic         dec_cmd,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         sealed,
  output logic [1:0]   state
);

  localparam logic [W-1:0] ZERO = '0;

  seal_cmd_t   cmd;
  seal_act_e   act;
  seal_state_e cur_q;
  seal_state_e nxt;

  assign cmd = '{wipe: clr_cmd, key: key_cmd, seal: enc_cmd, open: dec_cmd};

  xor_seal_arbiter i_arb (
    .cmd (cmd),
    .cur (cur_q),
    .act (act),
    .nxt (nxt)
  );

  xor_seal_regs #(.W(W)) i_regs (
    .clk    (clk),
    .rst    (rst),
    .act    (act),
    .din    (din),
    .data_q (dout)
  );

  always_ff @(posedge clk) begin
    if (rst) cur_q <= ST_EMPTY;
    else     cur_q <= nxt;
  end

  assign full   = (cur_q == ST_CIPHER) || (cur_q == ST_PLAIN);
  assign sealed = (cur_q == ST_CIPHER);
  assign state  = cur_q;

  // R6
  plain_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_q == ST_PLAIN) |=> (cur_q != ST_PLAIN));

  // R7
  empty_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_q == ST_EMPTY && !clr_cmd && !key_cmd) |=> (cur_q == ST_EMPTY && dout == ZERO));

  // R10
  flag_order_chk: assert property (@(posedge clk) disable iff (rst)
    sealed |-> full);

  // R10
  idle_dout_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !full |-> (dout == ZERO));

endmodule

// File: tb/test_xor_seal_fsm.sv
module test_xor_seal_fsm;

  logic       clk = 1'b0;
  logic       rst;
  logic       clr_cmd, key_cmd, enc_cmd, dec_cmd;
  logic [7:0] din;
  logic [7:0] dout;
  logic       full, sealed;
  logic [1:0] state;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  xor_seal_fsm #(.W(8)) i_xor_seal_fsm (
    .clk(clk), .rst(rst), .clr_cmd(clr_cmd), .key_cmd(key_cmd),
    .enc_cmd(enc_cmd), .dec_cmd(dec_cmd), .din(din),
    .dout(dout), .full(full), .sealed(sealed), .state(state)
  );

  // {cmd[clr,key,enc,dec], din, exp_state, exp_dout, req}; key becomes 5A first
  localparam logic [25:0] VEC [17] = '{
    {4'b0100, 8'h5A, 2'd1, 8'h00, 4'd3},  // R3 load key
    {4'b0010, 8'h3C, 2'd2, 8'h66, 4'd4},  // R4 encrypt
    {4'b0000, 8'h00, 2'd2, 8'h66, 4'd9},  // R9 hold
    {4'b0001, 8'h00, 2'd3, 8'h3C, 4'd5},  // R5 decrypt
    {4'b0000, 8'h00, 2'd1, 8'h00, 4'd6},  // R6 scrub
    {4'b0001, 8'h00, 2'd1, 8'h00, 4'd8},  // R8 decrypt in keyed state
    {4'b0010, 8'hFF, 2'd2, 8'hA5, 4'd4},  // R4
    {4'b0011, 8'h00, 2'd2, 8'h5A, 4'd4},  // R4 encrypt beats decrypt
    {4'b0001, 8'h00, 2'd3, 8'h00, 4'd5},  // R5
    {4'b0010, 8'h11, 2'd2, 8'h4B, 4'd4},  // R4 encrypt over plaintext
    {4'b0001, 8'h00, 2'd3, 8'h11, 4'd5},  // R5
    {4'b0001, 8'h00, 2'd1, 8'h00, 4'd8},  // R8 decrypt in plaintext state
    {4'b0110, 8'hC3, 2'd1, 8'h00, 4'd3},  // R3 key beats encrypt
    {4'b0010, 8'hC3, 2'd2, 8'h00, 4'd4},  // R4 new key used
    {4'b1111, 8'h77, 2'd0, 8'h00, 4'd2},  // R2 clear beats all
    {4'b0010, 8'h12, 2'd0, 8'h00, 4'd7},  // R7 encrypt without key
    {4'b0001, 8'h00, 2'd0, 8'h00, 4'd7}   // R7 decrypt without key
  };

  task automatic chk(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R10 flags follow the state code
  task automatic chk_all(input int req, input logic [1:0] est, input logic [7:0] ed);
    chk(req, "state", {6'd0, state}, {6'd0, est});
    chk(req, "dout", dout, ed);
    chk(10, "full", {7'd0, full}, {7'd0, est >= 2'd2});
    chk(10, "sealed", {7'd0, sealed}, {7'd0, est == 2'd2});
  endtask

  task automatic apply(input logic [3:0] c, input logic [7:0] d);
    @(negedge clk);
    {clr_cmd, key_cmd, enc_cmd, dec_cmd} = c;
    din = d;
    @(posedge clk);
    #5;
  endtask

  initial begin
    {clr_cmd, key_cmd, enc_cmd, dec_cmd} = 4'b0;
    din = 8'h00;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #5;
    chk_all(1, 2'd0, 8'h00);  // R1 reset state
    @(negedge clk) rst = 1'b0;

    foreach (VEC[i]) begin
      apply(VEC[i][25:22], VEC[i][21:14]);
      chk_all(int'(VEC[i][3:0]), VEC[i][13:12], VEC[i][11:4]);
    end

    // R11: nothing moves before the sampling edge
    apply(4'b0100, 8'h0F);
    @(negedge clk);
    {clr_cmd, key_cmd, enc_cmd, dec_cmd} = 4'b0010;
    din = 8'hF0;
    #5;
    chk(11, "dout before edge", dout, 8'h00);
    chk(11, "state before edge", {6'd0, state}, 8'd1);
    @(posedge clk);
    #5;
    chk_all(11, 2'd2, 8'hFF);

    // R2 clear from ciphertext state
    apply(4'b1000, 8'h00);
    chk_all(2, 2'd0, 8'h00);

    // R2 clear from plaintext state
    apply(4'b0100, 8'h0F);
    apply(4'b0010, 8'h33);
    chk_all(4, 2'd2, 8'h3C);
    apply(4'b0001, 8'h00);
    chk_all(5, 2'd3, 8'h33);
    apply(4'b1000, 8'h00);
    chk_all(2, 2'd0, 8'h00);

    // R1 reset in the middle of operation
    apply(4'b0100, 8'hAA);
    apply(4'b0010, 8'h01);
    chk_all(4, 2'd2, 8'hAB);
    @(negedge clk);
    {clr_cmd, key_cmd, enc_cmd, dec_cmd} = 4'b0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #5;
    chk_all(1, 2'd0, 8'h00);
    @(negedge clk) rst = 1'b0;
    apply(4'b0000, 8'h00);
    chk_all(1, 2'd0, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule